// File: doc/BRIEF.md
# Timed Pattern Output Controller

This block paces a digital output pattern at a programmed rate. A host sets a period through a byte-wide register interface. A reloadable down-counter then produces a periodic active-low request strobe, and each strobe's rising edge raises a data-ready flag. The host answers that flag by polling it, or through an interrupt request or a DMA request. It answers by writing the next pattern word to the output port, and that write also clears the flag.

The output port works in one of two ways. In direct mode a pattern write drives the pins on the next clock. In buffered mode a pattern write fills a holding register, and the holding register moves to the pins at the next strobe's trailing edge. This keeps the pin updates locked to the programmed rate, however late the host services each request. If a strobe arrives while the flag is still set, the word for that interval was missed, and a sticky underrun bit records it.

Register map: address 0 is the count byte port, address 1 is the control byte, and address 2 is the command byte. In the control byte, bit 0 is run, bit 1 is wide count, bit 2 is buffered output, bit 3 is interrupt enable and bit 4 is DMA enable. In the command byte, bit 0 clears the handshake state.

Top module: `pattern_rate_ctrl`

## Requirements
- R1: After reset, reqN is 1, dataReady, irq, dmaReq and underrun are 0, and patOut is all zeros.
- R2: In narrow mode (control bit 1 = 0), one write to address 0 sets the period P to that byte. Setting control bit 0 from 0 to 1 starts counting. reqN then goes low for exactly one cycle, and that cycle is the P-th clock cycle after the enabling write's edge. The low cycle repeats every P cycles while running.
- R3: In wide mode (control bit 1 = 1), the period is built from two successive writes to address 0: the low byte first, then the high byte. Any write to address 1 resets this byte order to "low byte next".
- R4: A programmed period of 0 or 1 behaves as a period of 2.
- R5: The trailing edge of each reqN low pulse sets dataReady, so dataReady is 1 in the cycle after reqN was low.
- R6: A pattern write (patWr) clears dataReady. A strobe that ends while dataReady is set, with no pattern write in the same cycle, sets underrun. underrun stays set until a write of 1 to bit 0 of address 2, which clears both dataReady and underrun.
- R7: irq equals dataReady gated by control bit 3. dmaReq equals dataReady gated by control bit 4.
- R8: With control bit 2 = 0, patOut shows a written pattern word from the cycle after the write.
- R9: With control bit 2 = 1, a pattern write leaves patOut unchanged. The held word reaches patOut at the trailing edge of the next strobe.
- R10: Clearing control bit 0 holds reqN high and halts the counter. Setting the bit again restarts a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | 8 | Register write byte |
| patWr | input | 1 | Pattern word write strobe |
| patData | input | DATA_W | Pattern word |
| reqN | output | 1 | Active-low rate strobe |
| dataReady | output | 1 | Host service flag |
| irq | output | 1 | Interrupt request |
| dmaReq | output | 1 | DMA request |
| underrun | output | 1 | Sticky missed-word status |
| patOut | output | DATA_W | Pattern output pins |

## Verification
The first reqN low cycle is due P cycles after the enabling edge, and each later one follows P cycles after the last. dataReady and a buffered pin transfer are due one cycle after each low cycle. A direct pin write is due one cycle after patWr. The driver works out each expected strobe cycle from the period it programs and queues it, together with the pattern expected afterwards. A monitor samples on the falling clock edge. On each strobe it pops the queue head and compares the cycle number, and one cycle later it checks the flag and the pins. A strobe that arrives early, late or unannounced is reported against its requirement, and so is a queued strobe that never arrives.

// File: rtl/pattern_pkg.sv
package pattern_pkg;
  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_COUNT = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_CMD   = 2'd2;

  localparam int CTRL_W   = 5;
  localparam int BIT_RUN  = 0;
  localparam int BIT_WIDE = 1;
  localparam int BIT_DBUF = 2;
  localparam int BIT_IRQ  = 3;
  localparam int BIT_DMA  = 4;
  localparam int BIT_CLR  = 0;

  typedef struct packed {
    logic holdLoad;
    logic pinLoad;
    logic xfer;
  } dpStrobe_t;
endpackage

// File: rtl/pattern_ctrl.sv
module pattern_ctrl
  import pattern_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic                  patWr,
  output logic                  reqN,
  output logic                  dataReady,
  output logic                  irq,
  output logic                  dmaReq,
  output logic                  underrun,
  output dpStrobe_t             strobes
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CTRL_W-1:0] ctrlReg;
  logic [BYTE_W-1:0] cntLo;
  logic [BYTE_W-1:0] cntHi;
  logic              highNext;
  logic [CNT_W-1:0]  cnt;

  logic run;
  logic wrCount;
  logic wrCtrl;
  logic clrCmd;
  logic loadNow;
  logic strobeEnd;

  function automatic logic [CNT_W-1:0] periodOf(input logic [BYTE_W-1:0] lo,
                                                input logic [BYTE_W-1:0] hi,
                                                input logic wide);
    logic [CNT_W-1:0] v;
    v = wide ? {hi, lo} : {{BYTE_W{1'b0}}, lo};
    if (v < CNT_W'(2)) v = CNT_W'(2);
    return v;
  endfunction

  assign run       = ctrlReg[BIT_RUN];
  assign wrCount   = wrEn && (wrAddr == ADDR_COUNT);
  assign wrCtrl    = wrEn && (wrAddr == ADDR_CTRL);
  assign clrCmd    = wrEn && (wrAddr == ADDR_CMD) && wrData[BIT_CLR];
  assign loadNow   = wrCtrl && wrData[BIT_RUN] && !run;
  assign strobeEnd = run && (cnt == CNT_W'(1));

  // control byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (wrCtrl) ctrlReg <= wrData[CTRL_W-1:0];
  end

  // count register with low-then-high byte order in wide mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLo    <= '0;
      cntHi    <= '0;
      highNext <= 1'b0;
    end else if (wrCtrl) begin
      highNext <= 1'b0;
    end else if (wrCount) begin
      if (!ctrlReg[BIT_WIDE]) begin
        cntLo    <= wrData;
        cntHi    <= '0;
        highNext <= 1'b0;
      end else if (!highNext) begin
        cntLo    <= wrData;
        highNext <= 1'b1;
      end else begin
        cntHi    <= wrData;
        highNext <= 1'b0;
      end
    end
  end

  // reloading down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (loadNow) cnt <= periodOf(cntLo, cntHi, wrData[BIT_WIDE]);
    else if (strobeEnd) cnt <= periodOf(cntLo, cntHi, ctrlReg[BIT_WIDE]);
    else if (run) cnt <= cnt - CNT_W'(1);
  end

  assign reqN = !strobeEnd;

  // handshake flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReady <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      if (strobeEnd) dataReady <= 1'b1;
      else if (patWr || clrCmd) dataReady <= 1'b0;

      if (strobeEnd && dataReady && !patWr) underrun <= 1'b1;
      else if (clrCmd) underrun <= 1'b0;
    end
  end

  assign irq    = dataReady && ctrlReg[BIT_IRQ];
  assign dmaReq = dataReady && ctrlReg[BIT_DMA];

  always_comb begin
    strobes.holdLoad = patWr && ctrlReg[BIT_DBUF];
    strobes.pinLoad  = patWr && !ctrlReg[BIT_DBUF];
    strobes.xfer     = strobeEnd && ctrlReg[BIT_DBUF];
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqN |=> reqN); // R2
  AST_READY_ON_TRAIL: assert property (@(posedge clk) disable iff (!rstN)
    !reqN |=> dataReady); // R5
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !clrCmd) |=> underrun); // R6
  AST_MIN_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (cnt != '0)); // R4
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !loadNow) |=> $stable(cnt)); // R10
endmodule

// File: rtl/pattern_dp.sv
module pattern_dp
  import pattern_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] patData,
  input  dpStrobe_t         strobes,
  output logic [DATA_W-1:0] patOut
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] pinReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdReg <= '0;
    else if (strobes.holdLoad) holdReg <= patData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinReg <= '0;
    else if (strobes.pinLoad) pinReg <= patData;
    else if (strobes.xfer) pinReg <= holdReg;
  end

  assign patOut = pinReg;

  AST_PINS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.pinLoad || strobes.xfer) |=> $stable(patOut)); // R9
  AST_DIRECT_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pinLoad |=> (patOut == $past(patData))); // R8
endmodule

// File: rtl/pattern_rate_ctrl.sv
module pattern_rate_ctrl
  import pattern_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              patWr,
  input  logic [DATA_W-1:0] patData,
  output logic              reqN,
  output logic              dataReady,
  output logic              irq,
  output logic              dmaReq,
  output logic              underrun,
  output logic [DATA_W-1:0] patOut
);
  dpStrobe_t strobes;

  pattern_ctrl #(.BYTE_W(BYTE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .patWr(patWr), .reqN(reqN), .dataReady(dataReady), .irq(irq),
    .dmaReq(dmaReq), .underrun(underrun), .strobes(strobes)
  );

  pattern_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .patData(patData), .strobes(strobes),
    .patOut(patOut)
  );
endmodule

// File: tb/sim_pattern_rate_ctrl.sv
`timescale 1ns/1ps
module sim_pattern_rate_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        patWr = 1'b0;
  logic [15:0] patData = '0;
  logic        reqN, dataReady, irq, dmaReq, underrun;
  logic [15:0] patOut;

  pattern_rate_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .patWr(patWr), .patData(patData), .reqN(reqN), .dataReady(dataReady),
    .irq(irq), .dmaReq(dmaReq), .underrun(underrun), .patOut(patOut)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    longint    at;
    bit        chk;
    logic [15:0] pat;
    string     tag;
  } exp_t;

  exp_t   sb[$];
  longint cyc = 0;
  int     nChecks = 0;
  int     nFail = 0;
  bit     pending = 0;
  exp_t   pendItem;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: pop expected strobes, then check flag and pins one cycle later
  always @(negedge clk) begin
    if (rstN) begin
      if (pending) begin
        check(dataReady == 1'b1, "R5 ready after strobe", longint'(dataReady), 1);
        if (pendItem.chk)
          check(patOut == pendItem.pat, "R9 buffered transfer", longint'(patOut), longint'(pendItem.pat));
        pending = 0;
      end
      if (!reqN) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 unexpected strobe", cyc, -1);
        end else begin
          pendItem = sb.pop_front();
          check(cyc == pendItem.at, pendItem.tag, cyc, pendItem.at);
          pending = 1;
        end
      end
    end
  end

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic patWrite(input logic [15:0] d);
    patWr = 1'b1; patData = d;
    @(negedge clk);
    patWr = 1'b0;
  endtask

  task automatic runStrobes(input logic [7:0] ctrlVal, input longint p, input int n,
                            input bit chk, input logic [15:0] pat, input string tag);
    longint c;
    longint last;
    exp_t   it;
    c = cyc;
    for (int i = 0; i < n; i++) begin
      it.at = c + p + i * p; it.chk = chk; it.pat = pat; it.tag = tag;
      sb.push_back(it);
    end
    last = c + p * n;
    regWrite(2'd1, ctrlVal);
    while (cyc < last) @(negedge clk);
    regWrite(2'd1, ctrlVal & 8'hFE);
    check(sb.size() == 0, {tag, " all strobes seen"}, sb.size(), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqN == 1'b1, "R1 reqN", longint'(reqN), 1);
    check({dataReady, irq, dmaReq, underrun} == 4'b0, "R1 flags",
          longint'({dataReady, irq, dmaReq, underrun}), 0);
    check(patOut == 16'h0, "R1 patOut", longint'(patOut), 0);

    // R2 narrow period 5, irq enabled, no service
    regWrite(2'd1, 8'h00);
    regWrite(2'd0, 8'd5);
    regWrite(2'd2, 8'h01);
    runStrobes(8'h09, 5, 3, 0, 16'h0, "R2 narrow period");
    check(irq == 1'b1, "R7 irq gated on", longint'(irq), 1);
    check(dmaReq == 1'b0, "R7 dma gated off", longint'(dmaReq), 0);
    check(underrun == 1'b1, "R6 underrun set", longint'(underrun), 1);
    for (int i = 0; i < 8; i++) begin
      check(reqN == 1'b1, "R10 idle high", longint'(reqN), 1);
      @(negedge clk);
    end
    regWrite(2'd2, 8'h01);
    check({dataReady, underrun} == 2'b00, "R6 clear command",
          longint'({dataReady, underrun}), 0);

    // R3 wide period 300 = 0x012C, dma enabled
    regWrite(2'd1, 8'h02);
    regWrite(2'd0, 8'h2C);
    regWrite(2'd0, 8'h01);
    runStrobes(8'h13, 300, 2, 0, 16'h0, "R3 wide period");
    check(dmaReq == 1'b1, "R7 dma gated on", longint'(dmaReq), 1);
    check(irq == 1'b0, "R7 irq gated off", longint'(irq), 0);

    // R4 periods 0 and 1 act as 2
    regWrite(2'd1, 8'h00);
    regWrite(2'd0, 8'd0);
    runStrobes(8'h01, 2, 3, 0, 16'h0, "R4 period zero");
    regWrite(2'd0, 8'd1);
    runStrobes(8'h01, 2, 3, 0, 16'h0, "R4 period one");

    // R8 direct write, R6 write clears ready
    check(dataReady == 1'b1, "R6 ready before write", longint'(dataReady), 1);
    patWrite(16'hA5A5);
    check(patOut == 16'hA5A5, "R8 direct write", longint'(patOut), 16'hA5A5);
    check(dataReady == 1'b0, "R6 write clears ready", longint'(dataReady), 0);

    // R9 buffered output
    regWrite(2'd2, 8'h01);
    regWrite(2'd1, 8'h04);
    regWrite(2'd0, 8'd6);
    patWrite(16'h1234);
    check(patOut == 16'hA5A5, "R9 write held back", longint'(patOut), 16'hA5A5);
    runStrobes(8'h05, 6, 1, 1, 16'h1234, "R9 buffered strobe");
    check(underrun == 1'b0, "R6 serviced no underrun", longint'(underrun), 0);
    patWrite(16'h5678);
    repeat (3) @(negedge clk);
    check(patOut == 16'h1234, "R9 hold while stopped", longint'(patOut), 16'h1234);
    runStrobes(8'h05, 6, 1, 1, 16'h5678, "R9 second transfer");

    // R10 stop mid-period then restart with full period
    regWrite(2'd1, 8'h00);
    regWrite(2'd0, 8'd7);
    regWrite(2'd1, 8'h01);
    repeat (3) @(negedge clk);
    regWrite(2'd1, 8'h00);
    for (int i = 0; i < 4; i++) begin
      check(reqN == 1'b1, "R10 halted high", longint'(reqN), 1);
      @(negedge clk);
    end
    runStrobes(8'h01, 7, 2, 0, 16'h0, "R10 restart full period");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule